// File: doc/BRIEF.md
# Quadrature Encoder to Up/Down Pulse Converter

This block turns the two phase-shifted tracks of an incremental encoder into two separate active-low pulse trains. One train counts up and the other counts down, so a plain up/down counter can be driven straight from them. A direction level and an active-low marker pulse for the index track are produced on the same clock as the count pulses. Both encoder tracks and the index line are asynchronous, so each passes through a two-flop synchroniser. The two encoder tracks also pass through a digital stability filter, which removes dither before any edge is decoded.

Two static select pins set the resolution: one, two or four counts per quadrature cycle. The width of every output pulse is set in system clocks by an input word. If a new count arrives while a pulse is still low, the pulse is stretched, and an overrun strobe records that the two counts have merged. If both tracks change together, the change is treated as a fault. No count is made and an error strobe is raised.

Top module: `qclk_conv`

## Requirements
- R1: Mode select: `sel_x2_ni` low gives x2 whatever `sel_x4_i` is. `sel_x2_ni` high with `sel_x4_i` low gives x1. Both high gives x4.
- R2: In x4 mode every legal edge of filtered A or B gives one pulse. An A edge whose new A differs from B counts up. A B edge whose new B equals A counts up. Every other legal edge counts down. Up counts pulse `up_no` and down counts pulse `dn_no`.
- R3: In x2 mode only legal edges of A give pulses, with the same direction rule as R2. B edges give none.
- R4: In x1 mode only a rising A edge that counts up, or a falling A edge that counts down, gives a pulse. This is one pulse per quadrature cycle.
- R5: `dir_o` is 1 for up and 0 for down. It takes the direction of each legal single edge in every mode, and it changes on the same clock on which that edge's pulse starts.
- R6: `idx_no` pulses low on every legal A edge seen while the synchronised index input is 1 and filtered B is 0, in any mode.
- R7: A filtered track takes a new level only after its synchronised input has been sampled equal on FILT_CYCLES+1 consecutive clocks. Shorter glitches give no pulse and leave `dir_o` unchanged.
- R8: When filtered A and B change on the same clock, no pulse is made and `dir_o` keeps its value. `illegal_o` is high for exactly one clock.
- R9: A pulse stays low for `pw_cycles_i` clocks. A value of 0 is treated as 1. The pulse starts one clock after the filtered edge is decoded.
- R10: A new trigger on an output whose pulse is still low reloads the full width, so the output stays low. `overrun_o` is then high for one clock. Triggers spaced further apart than the width never raise it.
- R11: While reset is asserted, all pulse outputs are 1, `dir_o` is 1 and both strobes are 0. After reset, the first filtered A/B state becomes the previous state and makes no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Encoder track A, asynchronous |
| b_i | input | 1 | Encoder track B, asynchronous |
| idx_i | input | 1 | Encoder index track, asynchronous |
| sel_x2_ni | input | 1 | Low selects x2 resolution |
| sel_x4_i | input | 1 | With `sel_x2_ni` high: 1 selects x4, 0 selects x1 |
| pw_cycles_i | input | PW_W | Output pulse width in clocks (0 acts as 1) |
| up_no | output | 1 | Up count pulses, active low |
| dn_no | output | 1 | Down count pulses, active low |
| dir_o | output | 1 | Count direction, 1 = up |
| idx_no | output | 1 | Index marker pulses, active low |
| illegal_o | output | 1 | One-clock strobe on a simultaneous A/B change |
| overrun_o | output | 1 | One-clock strobe when a pulse is retriggered while low |

## Verification
The bench drives random forward and backward steps, two-clock glitches and double-track jumps in each of the three modes. It checks these against counts predicted from the requirements. A decoder that swaps the direction rule for B edges would mix up and down counts in x4 mode. A wrong x1 qualifier would count twice per cycle or count on the wrong A edge. A filter that is too short would turn glitches into counts. Directed cases measure the pulse width at its nominal value and at 0, and overlap two counts so the stretched pulse and the overrun strobe can be seen. They also release reset with both tracks high, where a decoder that is not primed would make a false count.

// File: rtl/qc_pkg.sv
package qc_pkg;
  typedef enum logic [1:0] {
    MODE_X1 = 2'd0,
    MODE_X2 = 2'd1,
    MODE_X4 = 2'd2
  } qc_mode_e;

  function automatic qc_mode_e qc_mode_sel(input logic x2_n, input logic x4);
    if (!x2_n)   return MODE_X2;
    else if (x4) return MODE_X4;
    else         return MODE_X1;
  endfunction
endpackage

// File: rtl/qc_filter.sv
module qc_filter #(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic lvl_o,
  output logic valid_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1) < 1 ? 1 : $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_CYCLES);
  localparam logic [CW-1:0] CNT_ACC = CW'(FILT_CYCLES - 1);

  logic [1:0]    sync_q;
  logic          last_q;
  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          valid_q;
  logic          same;

  assign same = (sync_q[1] == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      last_q  <= 1'b0;
      cnt_q   <= '0;
      lvl_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      last_q <= sync_q[1];
      if (!same)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (same && cnt_q >= CNT_ACC) begin
        lvl_q   <= sync_q[1];
        valid_q <= 1'b1;
      end
    end
  end

  assign lvl_o   = lvl_q;
  assign valid_o = valid_q;

  AST_FILT_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && $past(valid_q) && lvl_q != $past(lvl_q)) |-> (lvl_q == $past(last_q))); // R7
endmodule

// File: rtl/qc_decode.sv
module qc_decode
  import qc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     a_i,
  input  logic     b_i,
  input  logic     ab_valid_i,
  input  logic     idx_i,
  input  qc_mode_e mode_i,
  output logic     up_trig_o,
  output logic     dn_trig_o,
  output logic     idx_trig_o,
  output logic     dir_o,
  output logic     illegal_o
);
  logic armed_q, pa_q, pb_q, dir_q, ill_q;
  logic ea, eb, sa, sb, fwd, cnt_en;

  assign ea  = armed_q && ab_valid_i && (a_i != pa_q);
  assign eb  = armed_q && ab_valid_i && (b_i != pb_q);
  assign sa  = ea && !eb;
  assign sb  = eb && !ea;
  // A edge counts up when new A differs from B; B edge when new B equals A
  assign fwd = sa ? (a_i ^ b_i) : !(a_i ^ b_i);

  always_comb begin
    unique case (mode_i)
      MODE_X4: cnt_en = sa || sb;
      MODE_X2: cnt_en = sa;
      MODE_X1: cnt_en = sa && (a_i ? fwd : !fwd);
      default: cnt_en = 1'b0;
    endcase
  end

  assign up_trig_o  = cnt_en && fwd;
  assign dn_trig_o  = cnt_en && !fwd;
  assign idx_trig_o = sa && idx_i && !b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pa_q    <= 1'b0;
      pb_q    <= 1'b0;
      dir_q   <= 1'b1;
      ill_q   <= 1'b0;
    end else begin
      ill_q <= ea && eb;
      if (ab_valid_i) begin
        pa_q    <= a_i;
        pb_q    <= b_i;
        armed_q <= 1'b1;
      end
      if (sa || sb) dir_q <= fwd;
    end
  end

  assign dir_o     = dir_q;
  assign illegal_o = ill_q;

  AST_ILL_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ill_q |-> $stable(dir_q)); // R8
  AST_X1_RISE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_X1 && up_trig_o) |-> (a_i && !pa_q)); // R4
endmodule

// File: rtl/qc_pulse.sv
module qc_pulse #(
  parameter int PW_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic [PW_W-1:0] pw_i,
  output logic            pulse_no,
  output logic            overrun_o
);
  logic [PW_W-1:0] cnt_q, pw_eff;
  logic            ovr_q;

  assign pw_eff = (pw_i == '0) ? PW_W'(1) : pw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      ovr_q <= trig_i && (cnt_q != '0);
      if (trig_i)             cnt_q <= pw_eff;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pulse_no  = (cnt_q == '0);
  assign overrun_o = ovr_q;

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> !pulse_no); // R9
  AST_OVR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> !$past(pulse_no)); // R10
endmodule

// File: rtl/qclk_conv.sv
module qclk_conv
  import qc_pkg::*;
#(
  parameter int FILT_CYCLES = 4,
  parameter int PW_W        = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            a_i,
  input  logic            b_i,
  input  logic            idx_i,
  input  logic            sel_x2_ni,
  input  logic            sel_x4_i,
  input  logic [PW_W-1:0] pw_cycles_i,
  output logic            up_no,
  output logic            dn_no,
  output logic            dir_o,
  output logic            idx_no,
  output logic            illegal_o,
  output logic            overrun_o
);
  localparam int NCH  = 2;
  localparam int NOUT = 3;

  logic [NCH-1:0]  raw, lvl, vld;
  logic [1:0]      idx_sync_q;
  logic [NOUT-1:0] trig, pls_n, ovr;
  qc_mode_e        mode;

  assign raw  = {b_i, a_i};
  assign mode = qc_mode_sel(sel_x2_ni, sel_x4_i);

  for (genvar c = 0; c < NCH; c++) begin : g_filt
    qc_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_i   (raw[c]),
      .lvl_o   (lvl[c]),
      .valid_o (vld[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_sync_q <= '0;
    else         idx_sync_q <= {idx_sync_q[0], idx_i};
  end

  qc_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_i        (lvl[0]),
    .b_i        (lvl[1]),
    .ab_valid_i (&vld),
    .idx_i      (idx_sync_q[1]),
    .mode_i     (mode),
    .up_trig_o  (trig[0]),
    .dn_trig_o  (trig[1]),
    .idx_trig_o (trig[2]),
    .dir_o      (dir_o),
    .illegal_o  (illegal_o)
  );

  for (genvar g = 0; g < NOUT; g++) begin : g_pls
    qc_pulse #(.PW_W(PW_W)) u_pls (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .trig_i    (trig[g]),
      .pw_i      (pw_cycles_i),
      .pulse_no  (pls_n[g]),
      .overrun_o (ovr[g])
    );
  end

  assign up_no     = pls_n[0];
  assign dn_no     = pls_n[1];
  assign idx_no    = pls_n[2];
  assign overrun_o = |ovr;

  AST_UP_DN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trig[0] && trig[1])); // R2
  AST_ILL_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($stable(up_no) || up_no) && ($stable(dn_no) || dn_no)); // R8
endmodule

// File: tb/qclk_conv_test.sv
`timescale 1ns/1ps
module qclk_conv_test;
  localparam int HOLD = 24;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic a_i = 1'b1, b_i = 1'b1, idx_i = 1'b0;
  logic sel_x2_ni = 1'b1, sel_x4_i = 1'b1;
  logic [3:0] pw_cycles_i = 4'd3;
  logic up_no, dn_no, dir_o, idx_no, illegal_o, overrun_o;

  int nchk = 0, nfail = 0;
  int up_cnt = 0, dn_cnt = 0, ix_cnt = 0, ill_cnt = 0, ovr_cnt = 0, up_low = 0;
  int e_up = 0, e_dn = 0, e_ix = 0, e_ill = 0;
  int mode_m = 2; // 0 x1, 1 x2, 2 x4
  logic ma = 1'b1, mb = 1'b1, mdir = 1'b1;
  bit done = 0;

  always #2.5 clk = ~clk;

  qclk_conv uut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .idx_i(idx_i),
    .sel_x2_ni(sel_x2_ni), .sel_x4_i(sel_x4_i), .pw_cycles_i(pw_cycles_i),
    .up_no(up_no), .dn_no(dn_no), .dir_o(dir_o), .idx_no(idx_no),
    .illegal_o(illegal_o), .overrun_o(overrun_o)
  );

  always @(negedge up_no)  if (rst_ni) up_cnt++;
  always @(negedge dn_no)  if (rst_ni) dn_cnt++;
  always @(negedge idx_no) if (rst_ni) ix_cnt++;
  always @(negedge clk) if (rst_ni) begin
    if (illegal_o) ill_cnt++;
    if (overrun_o) ovr_cnt++;
    if (!up_no)    up_low++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input int m);
    mode_m = m;
    sel_x2_ni = (m != 1);
    sel_x4_i  = (m == 2);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 up count"},  up_cnt,  e_up);
    chk({tag, " R2 down count"}, dn_cnt, e_dn);
    chk({tag, " R6 index count"}, ix_cnt, e_ix);
    chk({tag, " R8 illegal count"}, ill_cnt, e_ill);
    chk({tag, " R5 direction"}, int'(dir_o), int'(mdir));
  endtask

  // expected effect of moving the encoder to (na, nb)
  task automatic step(input logic na, input logic nb, input logic nidx);
    bit ach, bch, up, cnt;
    ach = (na != ma);
    bch = (nb != mb);
    if (ach && bch) e_ill++;
    else if (ach) begin
      up  = na ^ nb;
      cnt = (mode_m != 0) || (na == up);
      if (cnt) begin if (up) e_up++; else e_dn++; end
      if (nidx && !nb) e_ix++;
      mdir = up;
    end else if (bch) begin
      up = (na == nb);
      if (mode_m == 2) begin if (up) e_up++; else e_dn++; end
      mdir = up;
    end
    @(negedge clk);
    idx_i = nidx;
    wait_cyc(3);
    a_i = na; b_i = nb;
    ma = na; mb = nb;
    wait_cyc(HOLD);
  endtask

  function automatic logic [1:0] ph2ab(input int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  initial begin
    int unsigned sd;
    int ph;
    logic [1:0] ab;
    sd = $urandom(32'd7082);
    ph = 2; // a=1, b=1
    // R11: reset state, primed with both tracks high
    wait_cyc(4);
    chk("R11 up_no in reset", int'(up_no), 1);
    chk("R11 dir_o in reset", int'(dir_o), 1);
    rst_ni = 1'b1;
    wait_cyc(30);
    chk("R11 no pulse after reset up", up_cnt, 0);
    chk("R11 no pulse after reset dn", dn_cnt, 0);
    chk("R11 idle dn_no", int'(dn_no), 1);
    chk("R11 idle idx_no", int'(idx_no), 1);
    chk("R11 strobe idle", ill_cnt, 0);

    // R9: nominal width 3, then 0 acting as 1
    set_mode(2);
    up_low = 0;
    ph++; ab = ph2ab(ph); step(ab[1], ab[0], 1'b0);
    chk("R9 width 3", up_low, 3);
    pw_cycles_i = 4'd0;
    up_low = 0;
    ph++; ab = ph2ab(ph); step(ab[1], ab[0], 1'b0);
    chk("R9 width zero acts as one", up_low, 1);
    pw_cycles_i = 4'd3;
    check_all("directed");

    // R1 R2 R3 R4 R5 R6 R7 R8: random walks in each mode
    for (int m = 0; m < 3; m++) begin
      set_mode(m);
      wait_cyc(4);
      for (int s = 0; s < 60; s++) begin
        int r;
        logic nx;
        r  = int'($urandom_range(9, 0));
        nx = 1'($urandom_range(1, 0));
        if (r < 4)      ph++;
        else if (r < 8) ph--;
        else if (r == 9) ph += 2;
        if (r == 8) begin
          // R7: two-clock glitch on A must be ignored
          @(negedge clk); a_i = ~a_i;
          wait_cyc(2);    a_i = ~a_i;
          wait_cyc(HOLD);
        end else begin
          ab = ph2ab(ph);
          step(ab[1], ab[0], nx);
        end
        check_all(m == 0 ? "R1 R4 x1" : (m == 1 ? "R1 R3 x2" : "R1 R2 x4"));
      end
    end
    chk("R10 no overrun at wide spacing", ovr_cnt, 0);

    // R10: overlapping counts with width 15
    set_mode(2);
    pw_cycles_i = 4'd15;
    wait_cyc(4);
    ph = ph & 3;
    up_low = 0;
    begin
      int u0;
      u0 = up_cnt;
      ab = ph2ab(ph + 1);
      a_i = ab[1]; b_i = ab[0];
      wait_cyc(10);
      ab = ph2ab(ph + 2);
      a_i = ab[1]; b_i = ab[0];
      wait_cyc(40);
      chk("R10 single merged pulse", up_cnt - u0, 1);
      chk("R10 stretched low time", up_low, 25);
      chk("R10 overrun strobe", ovr_cnt, 1);
      chk("R5 dir after forward pair", int'(dir_o), 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule